// File: doc/BRIEF.md
# Floating-Point, Debug and Cycle-Counter Control Register File

This block holds the control and status state that sits beside a processor core's floating-point unit, its debug unit and its time-stamp counter. There is one write port, with a strobe, a 5-bit index and a 64-bit value. There is one read port, which is combinational from its own 5-bit index. Each write passes through a per-register rule before it is stored. The rule may truncate the value to the register's width, merge it into the stored value under a field mask, redirect it to another register, or convert it into an offset against a free-running cycle count.

The stack-top field of the floating-point status word has its own 3-bit register. It is copied from every status-word write, and it is spliced back into the status word on every read. The time-stamp counter never counts itself: the block stores the difference between the last written value and the cycle count, and adds the count back on read. Two debug indices are aliases of the debug status and debug control registers. A mode input chooses whether the instruction and operand pointer registers keep their full width.

Index map (5 bits): 0 control word, 1 status word, 2 tag word, 3 last opcode, 4 SIMD control/status, 5 instruction selector, 6 operand selector, 7 instruction offset, 8 operand offset, 9 stack-top, 10 time-stamp counter, 16 to 23 debug registers 0 to 7. Every other index is unimplemented.

Top module: `misc_rf`

## Requirements
- R1: After reset, debug register 6 (index 22) reads 0x0000_0000_FFFF_0FF0, debug register 7 (index 23) reads 0x0000_0000_0000_0400, and every other implemented register reads 0. The time-stamp counter (index 10) therefore reads the current cycle count.
- R2: A read of index 10 returns the stored offset plus `cycle_count`. A write to index 10 stores `wr_data - cycle_count`, using the count at the write edge. The counter then reads the written value plus the number of cycles elapsed since that edge.
- R3: A write to the status word (index 1) stores only bits 15:0 and also loads the stack-top register with `wr_data[13:11]`. A read of index 1 returns the stored word with bits 13:11 replaced by the stack-top register.
- R4: A write to the stack-top register (index 9) keeps only bits 2:0. The new value appears both at index 9 and in bits 13:11 of the status-word read.
- R5: Writes keep only the low bits of these registers: the tag word (index 2) keeps 8 bits, the control word and the last opcode (indices 0 and 3) keep 16 bits, and the SIMD control/status register (index 4) keeps 32 bits.
- R6: While `mode64` is 0, writes to the selectors (indices 5 and 6) keep 16 bits and writes to the offsets (indices 7 and 8) keep 32 bits. While `mode64` is 1, all four keep the full 64 bits.
- R7: Index 20 is an alias of index 22, and index 21 is an alias of index 23. This holds for both reads and writes.
- R8: A write to debug register 6 replaces only bits 3:0 and 15:13 (mask 0xE00F). All other bits keep their stored value.
- R9: A write to debug register 7 replaces only bits 7:0, bit 13 and bits 31:16 (mask 0xFFFF_20FF). All other bits keep their stored value.
- R10: `bp_unsup` is high for exactly the cycle after a write that reaches debug register 7 with any of bits 7:0 set. The write itself is still stored.
- R11: A read of an unimplemented index returns 0 with `rd_illegal` high. A write to an unimplemented index changes no register, and it drives `wr_illegal` high for the following cycle.
- R12: Debug registers 0 to 3 (indices 16 to 19) store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | High when the core runs in the 64-bit submode |
| cycle_count | input | 64 | Free-running cycle count |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write index |
| wr_data | input | 64 | Write value |
| rd_addr | input | 5 | Read index |
| rd_data | output | 64 | Read value (combinational) |
| rd_illegal | output | 1 | Read index is unimplemented (combinational) |
| wr_illegal | output | 1 | Previous cycle wrote an unimplemented index |
| bp_unsup | output | 1 | Previous cycle enabled a breakpoint in debug register 7 |

## Verification
A write is committed at the rising edge that samples the strobe. The read data and `rd_illegal` follow the read index within the same cycle, so the stored result of a write can be seen from the next cycle on. `wr_illegal` and `bp_unsup` are registered at the commit edge and stay valid only until the following edge. The scoreboard monitor therefore checks each queued item at the falling edge of the cycle in which it is popped. Flag items are pushed first after a write, so that they are checked inside that one-cycle window. Expected time-stamp values are held as offsets and have the bench's own cycle count added at the moment of sampling.

// File: rtl/misc_rf_pkg.sv
package misc_rf_pkg;
  localparam int AW    = 5;
  localparam int NSLOT = 1 << AW;

  localparam logic [AW-1:0] IX_FCW  = 5'd0;
  localparam logic [AW-1:0] IX_FSW  = 5'd1;
  localparam logic [AW-1:0] IX_FTW  = 5'd2;
  localparam logic [AW-1:0] IX_FOP  = 5'd3;
  localparam logic [AW-1:0] IX_SIMD = 5'd4;
  localparam logic [AW-1:0] IX_ISEL = 5'd5;
  localparam logic [AW-1:0] IX_OSEL = 5'd6;
  localparam logic [AW-1:0] IX_IOFF = 5'd7;
  localparam logic [AW-1:0] IX_OOFF = 5'd8;
  localparam logic [AW-1:0] IX_TOP  = 5'd9;
  localparam logic [AW-1:0] IX_TSC  = 5'd10;
  localparam logic [AW-1:0] IX_DR0  = 5'd16;
  localparam logic [AW-1:0] IX_DR4  = 5'd20;
  localparam logic [AW-1:0] IX_DR5  = 5'd21;
  localparam logic [AW-1:0] IX_DR6  = 5'd22;
  localparam logic [AW-1:0] IX_DR7  = 5'd23;

  localparam int TOP_LSB = 11;
  localparam int TOP_W   = 3;

  localparam logic [63:0] DR6_WMASK = 64'h0000_0000_0000_E00F;
  localparam logic [63:0] DR7_WMASK = 64'h0000_0000_FFFF_20FF;
  localparam logic [63:0] DR6_INIT  = 64'h0000_0000_FFFF_0FF0;
  localparam logic [63:0] DR7_INIT  = 64'h0000_0000_0000_0400;

  function automatic logic is_impl(input logic [AW-1:0] ix);
    return (ix <= IX_TSC) || (ix >= IX_DR0 && ix <= IX_DR7);
  endfunction

  function automatic logic [AW-1:0] fold_alias(input logic [AW-1:0] ix);
    if (ix == IX_DR4) return IX_DR6;
    if (ix == IX_DR5) return IX_DR7;
    return ix;
  endfunction

  function automatic logic has_storage(input logic [AW-1:0] ix);
    return is_impl(ix) && ix != IX_DR4 && ix != IX_DR5;
  endfunction

  function automatic logic [63:0] init_val(input logic [AW-1:0] ix);
    if (ix == IX_DR6) return DR6_INIT;
    if (ix == IX_DR7) return DR7_INIT;
    return 64'd0;
  endfunction
endpackage

// File: rtl/misc_rf_wpath.sv
module misc_rf_wpath
  import misc_rf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mode64,
  input  logic [DW-1:0] cycle_count,
  input  logic [DW-1:0] dr6_cur,
  input  logic [DW-1:0] dr7_cur,
  output logic          main_we,
  output logic [AW-1:0] main_idx,
  output logic [DW-1:0] main_val,
  output logic          top_we,
  output logic [DW-1:0] top_val,
  output logic          bad_wr,
  output logic          bp_hit
);
  localparam logic [DW-1:0] M3   = DW'(64'h7);
  localparam logic [DW-1:0] M8   = DW'(64'hFF);
  localparam logic [DW-1:0] M16  = DW'(64'hFFFF);
  localparam logic [DW-1:0] M32  = DW'(64'hFFFF_FFFF);
  localparam logic [DW-1:0] MDR6 = DW'(DR6_WMASK);
  localparam logic [DW-1:0] MDR7 = DW'(DR7_WMASK);

  logic legal;

  always_comb begin
    legal    = is_impl(wr_addr);
    main_idx = fold_alias(wr_addr);
    main_we  = wr_en && legal;
    bad_wr   = wr_en && !legal;
    top_we   = 1'b0;
    top_val  = '0;
    main_val = wr_data;
    case (main_idx)
      IX_FSW: begin
        main_val = wr_data & M16;
        top_we   = main_we;
        top_val  = DW'(wr_data[TOP_LSB +: TOP_W]);
      end
      IX_TOP:             main_val = wr_data & M3;
      IX_FTW:             main_val = wr_data & M8;
      IX_FCW, IX_FOP:     main_val = wr_data & M16;
      IX_SIMD:            main_val = wr_data & M32;
      IX_ISEL, IX_OSEL:   main_val = mode64 ? wr_data : (wr_data & M16);
      IX_IOFF, IX_OOFF:   main_val = mode64 ? wr_data : (wr_data & M32);
      IX_TSC:             main_val = wr_data - cycle_count;
      IX_DR6:             main_val = (dr6_cur & ~MDR6) | (wr_data & MDR6);
      IX_DR7:             main_val = (dr7_cur & ~MDR7) | (wr_data & MDR7);
      default:            main_val = wr_data;
    endcase
    bp_hit = main_we && (main_idx == IX_DR7) && (wr_data[7:0] != 8'd0);
  end
endmodule

// File: rtl/misc_rf_store.sv
module misc_rf_store
  import misc_rf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          main_we,
  input  logic [AW-1:0] main_idx,
  input  logic [DW-1:0] main_val,
  input  logic          top_we,
  input  logic [DW-1:0] top_val,
  output logic [DW-1:0] regs [NSLOT]
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [AW-1:0] SIX = AW'(s);
    if (has_storage(SIX)) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= DW'(init_val(SIX));
        end else if (SIX == IX_TOP && top_we) begin
          q <= top_val;
        end else if (main_we && main_idx == SIX) begin
          q <= main_val;
        end
      end
      assign regs[s] = q;
    end else begin : g_none
      assign regs[s] = '0;
    end
  end

  localparam logic [DW-1:0] MDR6 = DW'(DR6_WMASK);
  localparam logic [DW-1:0] MDR7 = DW'(DR7_WMASK);

  // R8: bits outside the status mask survive a debug-status write
  a_r8_dr6_keep: assert property (@(posedge clk) disable iff (rst)
    (main_we && main_idx == IX_DR6) |=>
      ((regs[IX_DR6] & ~MDR6) == ($past(regs[IX_DR6]) & ~MDR6)));

  // R9: bits outside the control mask survive a debug-control write
  a_r9_dr7_keep: assert property (@(posedge clk) disable iff (rst)
    (main_we && main_idx == IX_DR7) |=>
      ((regs[IX_DR7] & ~MDR7) == ($past(regs[IX_DR7]) & ~MDR7)));

  // R5: the tag word never holds bits above 7 after a write
  a_r5_ftw_width: assert property (@(posedge clk) disable iff (rst)
    (main_we && main_idx == IX_FTW) |=> (regs[IX_FTW][DW-1:8] == '0));
endmodule

// File: rtl/misc_rf_rpath.sv
module misc_rf_rpath
  import misc_rf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] regs [NSLOT],
  input  logic [DW-1:0] cycle_count,
  output logic [DW-1:0] rd_data,
  output logic          rd_illegal
);
  logic [AW-1:0] eff;
  logic [DW-1:0] raw;

  always_comb begin
    eff        = fold_alias(rd_addr);
    raw        = regs[eff];
    rd_illegal = !is_impl(rd_addr);
    rd_data    = raw;
    if (eff == IX_FSW) begin
      rd_data[TOP_LSB +: TOP_W] = regs[IX_TOP][TOP_W-1:0];
    end else if (eff == IX_TSC) begin
      rd_data = raw + cycle_count;
    end
    if (rd_illegal) rd_data = '0;
  end
endmodule

// File: rtl/misc_rf.sv
module misc_rf
  import misc_rf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode64,
  input  logic [DW-1:0] cycle_count,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_illegal,
  output logic          wr_illegal,
  output logic          bp_unsup
);
  logic          main_we, top_we, bad_wr, bp_hit;
  logic [AW-1:0] main_idx;
  logic [DW-1:0] main_val, top_val;
  logic [DW-1:0] regs [NSLOT];

  misc_rf_wpath #(.DW(DW)) u_wpath (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .mode64(mode64),
    .cycle_count(cycle_count), .dr6_cur(regs[IX_DR6]), .dr7_cur(regs[IX_DR7]),
    .main_we(main_we), .main_idx(main_idx), .main_val(main_val),
    .top_we(top_we), .top_val(top_val), .bad_wr(bad_wr), .bp_hit(bp_hit)
  );

  misc_rf_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst), .main_we(main_we), .main_idx(main_idx),
    .main_val(main_val), .top_we(top_we), .top_val(top_val), .regs(regs)
  );

  misc_rf_rpath #(.DW(DW)) u_rpath (
    .rd_addr(rd_addr), .regs(regs), .cycle_count(cycle_count),
    .rd_data(rd_data), .rd_illegal(rd_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_illegal <= 1'b0;
      bp_unsup   <= 1'b0;
    end else begin
      wr_illegal <= bad_wr;
      bp_unsup   <= bp_hit;
    end
  end

  // R11: a write to a hole raises the flag on the next cycle
  a_r11_wr_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_impl(wr_addr)) |=> wr_illegal);

  // R10: enabling a breakpoint through index 21 or 23 raises the flag
  a_r10_bp_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fold_alias(wr_addr) == IX_DR7 && wr_data[7:0] != 8'd0) |=> bp_unsup);

  // R2: the counter reads back the written value plus elapsed cycles
  a_r2_tsc_track: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == IX_TSC) |=>
      (rd_addr != IX_TSC || (rd_data - cycle_count) == ($past(wr_data) - $past(cycle_count))));

  // R3: a status-word write loads the stack-top register
  a_r3_top_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == IX_FSW) |=>
      (regs[IX_TOP][TOP_W-1:0] == $past(wr_data[TOP_LSB +: TOP_W])));
endmodule

// File: tb/misc_rf_test.sv
`timescale 1ns/1ps
module misc_rf_test;
  typedef struct {
    logic [4:0]  addr;
    logic [63:0] exp;
    int          kind;   // 0 data, 1 data+cycle, 2 rd_illegal, 3 wr_illegal, 4 bp_unsup
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst = 1'b1, mode64 = 1'b0;
  logic [63:0] cyc = 64'd0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_illegal, wr_illegal, bp_unsup;

  int    n_checks = 0, n_fail = 0;
  bit    finished = 1'b0;
  item_t sb [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 64'd1;

  misc_rf uut (
    .clk(clk), .rst(rst), .mode64(mode64), .cycle_count(cyc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_illegal(rd_illegal),
    .wr_illegal(wr_illegal), .bp_unsup(bp_unsup)
  );

  // expected-value helpers from the requirement text
  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic [63:0] m);
    return (old & ~m) | (d & m);
  endfunction

  task automatic push(input logic [4:0] a, input logic [63:0] e, input int k, input string t);
    item_t it;
    it.addr = a; it.exp = e; it.kind = k; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // monitor: pops one item per falling edge and compares
  initial begin
    forever begin
      item_t it;
      logic [63:0] act, exp;
      wait (sb.size() > 0);
      it = sb[0];
      rd_addr = it.addr;
      @(negedge clk);
      exp = it.exp;
      case (it.kind)
        0: act = rd_data;
        1: begin act = rd_data; exp = it.exp + cyc; end
        2: act = {63'd0, rd_illegal};
        3: act = {63'd0, wr_illegal};
        default: act = {63'd0, bp_unsup};
      endcase
      n_checks++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s idx=%0d kind=%0d actual=%h expected=%h", it.tag, it.addr, it.kind, act, exp);
      end
      void'(sb.pop_front());
    end
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] tsc_off, v, dr6m, dr7m, top, fsw;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset values
    push(5'd22, 64'h0000_0000_FFFF_0FF0, 0, "R1");
    push(5'd23, 64'h0000_0000_0000_0400, 0, "R1");
    push(5'd0,  64'd0, 0, "R1");
    push(5'd1,  64'd0, 0, "R1");
    push(5'd18, 64'd0, 0, "R1");
    push(5'd10, 64'd0, 1, "R1");
    drain();
    dr6m = 64'h0000_0000_FFFF_0FF0;
    dr7m = 64'h0000_0000_0000_0400;

    // R5 width masks
    wr(5'd2, '1); wr(5'd0, '1); wr(5'd3, 64'h1234_5678_9ABC_DEF0); wr(5'd4, '1);
    push(5'd2, 64'hFF, 0, "R5");
    push(5'd0, 64'hFFFF, 0, "R5");
    push(5'd3, 64'hDEF0, 0, "R5");
    push(5'd4, 64'hFFFF_FFFF, 0, "R5");
    drain();

    // R6 pointer masks depend on mode64
    mode64 = 1'b0;
    wr(5'd5, '1); wr(5'd7, '1);
    push(5'd5, 64'hFFFF, 0, "R6");
    push(5'd7, 64'hFFFF_FFFF, 0, "R6");
    drain();
    mode64 = 1'b1;
    wr(5'd6, 64'h1234_5678_9ABC_DEF0); wr(5'd8, 64'hFEDC_BA98_7654_3210);
    push(5'd6, 64'h1234_5678_9ABC_DEF0, 0, "R6");
    push(5'd8, 64'hFEDC_BA98_7654_3210, 0, "R6");
    drain();
    mode64 = 1'b0;

    // R3 status word and stack-top
    v = 64'h1234_5678_9ABC_F9A5;
    wr(5'd1, v);
    top = {61'd0, v[13:11]};
    fsw = v & 64'hFFFF;
    push(5'd1, (fsw & ~64'h3800) | (top << 11), 0, "R3");
    push(5'd9, top, 0, "R3");
    drain();
    // R4 direct stack-top write
    wr(5'd9, 64'hFFFF_FFFF_FFFF_FFF2);
    top = 64'd2;
    push(5'd9, top, 0, "R4");
    push(5'd1, (fsw & ~64'h3800) | (top << 11), 0, "R4");
    drain();

    // R2 time-stamp counter
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'd10; wr_data = 64'h1000_0000_0000_0000;
    tsc_off = 64'h1000_0000_0000_0000 - cyc;
    @(posedge clk); #1;
    wr_en = 1'b0;
    push(5'd10, tsc_off, 1, "R2");
    drain();
    repeat (5) @(posedge clk);
    push(5'd10, tsc_off, 1, "R2");
    drain();

    // R12 debug address registers
    wr(5'd17, '1);
    push(5'd17, '1, 0, "R12");
    drain();

    // R8 / R7 debug status
    wr(5'd22, '1);
    dr6m = merge(dr6m, '1, 64'hE00F);
    push(5'd22, dr6m, 0, "R8");
    drain();
    wr(5'd20, 64'd0);
    dr6m = merge(dr6m, 64'd0, 64'hE00F);
    push(5'd22, dr6m, 0, "R7");
    push(5'd20, dr6m, 0, "R7");
    drain();

    // R9 / R10 / R7 debug control
    wr(5'd23, 64'hFFFF_FFFF_FFFF_FF00);
    dr7m = merge(dr7m, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_20FF);
    push(5'd23, 64'd0, 4, "R10");
    push(5'd23, dr7m, 0, "R9");
    drain();
    wr(5'd21, 64'h81);
    dr7m = merge(dr7m, 64'h81, 64'hFFFF_20FF);
    push(5'd21, 64'd1, 4, "R10");
    push(5'd23, dr7m, 0, "R7");
    push(5'd21, dr7m, 0, "R9");
    drain();

    // R11 unimplemented indices
    push(5'd12, 64'd0, 0, "R11");
    push(5'd12, 64'd1, 2, "R11");
    push(5'd0,  64'd0, 2, "R11");
    drain();
    wr(5'd14, '1);
    push(5'd14, 64'd1, 3, "R11");
    push(5'd14, 64'd0, 0, "R11");
    push(5'd0,  64'hFFFF, 0, "R11");
    push(5'd0,  64'd0, 3, "R11");
    drain();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule